// File: doc/BRIEF.md
# Processor Low-Power State Controller

This controller tracks the power state of a multi-core processor package. Its states are run, halt, deep halt and stop-grant. Each idle state has its own snoop-service state. The package becomes idle only once every core reports that it has executed a halt or wait instruction. A strap selects whether the idle state is plain halt or deep halt. Deep halt also lowers the core operating point. The controller does not sequence that change itself: it passes the work to an external sequencer through a lower request with its done strobe, and a restore request with its done strobe.

An active-low stop-clock request can arrive from run, halt or deep halt. It starts an acknowledge bus cycle. Stop-grant becomes effective a fixed number of bus clocks after the response to that cycle. The state that was active before stop-grant is stored and restored when stop-clock is released.

While the package is stopped, SMI, INIT and the two local interrupt lines (NMI, INTR) are held in latches instead of being serviced. Each one is replayed as a single pulse when the controller next enters run. An active-low power status output tells the voltage regulator when the package is in a reduced-power state.

Top module: `lps_ctrl`

## Requirements
- R1: State codes are run=0, halt=1, deep=2, stop-grant=3, halt-snoop=4, deep-snoop=5, stop-grant-snoop=6, deep-entry=7, deep-exit=8, stop-grant-wait=9. Synchronous reset gives state 0, psi_n high, and all request and replay outputs low.
- R2: Run moves to an idle state only when every bit of core_halted is set. Any other pattern keeps run.
- R3: With all cores halted and deep_en low, run goes to halt (1). With deep_en high it goes to deep-entry (7) and holds oppt_lower_req high. It stays in deep-entry until oppt_lower_done, then moves to deep (2).
- R4: Any of SMI, INIT, NMI, INTR, bus interrupt or proc_reset moves halt to run. In deep the same events move to deep-exit (8), which holds oppt_restore_req high until oppt_restore_done and then moves to run.
- R5: stpclk_n low in run, halt or deep moves to stop-grant-wait (9). sg_ack_req is a single-cycle pulse in the first cycle of that state.
- R6: Stop-grant (3) is reached exactly SG_DELAY (20) clocks after the clock edge that samples sg_ack_rsp.
- R7: stpclk_n high in stop-grant returns the controller to the state that was active before the stop request (run, halt or deep).
- R8: proc_reset in stop-grant leaves the state in stop-grant.
- R9: In states 9, 3 and 6 the SMI, INIT, NMI and INTR inputs are latched. On the next entry to run, replay bits 0 to 3 (in that order) pulse once for one cycle, however many times each event arrived. A bus interrupt is ignored in those states.
- R10: A latched event pending when stop-grant ends with a return target of halt sends the controller to run. With a return target of deep it goes to deep-exit, and the replay follows on entry to run.
- R11: snoop_hit moves halt, deep and stop-grant to 4, 5 and 6 respectively. The controller stays there until snoop_done, then returns to the idle state it left.
- R12: psi_n is low exactly in states 1 to 6.
- R13: Deep-snoop keeps the lowered operating point: oppt_restore_req stays low there and deep resumes without a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high controller reset |
| core_halted | input | NCORES | Per-core halt-executed flags |
| deep_en | input | 1 | Strap selecting deep halt as the idle state |
| stpclk_n | input | 1 | Active-low stop-clock request |
| snoop_hit | input | 1 | Bus snoop detected strobe |
| snoop_done | input | 1 | Snoop serviced strobe (any agent) |
| proc_reset | input | 1 | Processor reset event |
| brk_smi | input | 1 | SMI break event |
| brk_init | input | 1 | INIT break event |
| brk_nmi | input | 1 | NMI local interrupt line |
| brk_intr | input | 1 | INTR local interrupt line |
| brk_bus | input | 1 | Bus-delivered interrupt |
| sg_ack_rsp | input | 1 | Response-phase strobe of the acknowledge cycle |
| oppt_lower_done | input | 1 | Operating point lowered |
| oppt_restore_done | input | 1 | Operating point restored |
| state | output | 4 | Current state code |
| sg_ack_req | output | 1 | Acknowledge cycle request pulse |
| psi_n | output | 1 | Active-low reduced-power indicator |
| oppt_lower_req | output | 1 | Request to lower ratio and voltage |
| oppt_restore_req | output | 1 | Request to restore ratio and voltage |
| replay | output | 4 | Replay pulses: SMI, INIT, NMI, INTR |

## Verification
The bench sweeps every core_halted pattern against both settings of deep_en. A controller that went idle on any single halted core would leave run early. The bench also sweeps all sixteen subsets of the latched events, with each event raised twice. A design that dropped a latch, replayed an event twice, or let the bus interrupt through would show a wrong replay word. The stop-grant delay is probed one clock before and exactly on its deadline to catch off-by-one counting. Return from stop-grant is exercised from run, halt and deep, both with and without pending events, so a lost return target or a pending event that fails to wake a halted package is exposed.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [3:0] {
    PS_RUN       = 4'd0,
    PS_HALT      = 4'd1,
    PS_DEEP      = 4'd2,
    PS_SGNT      = 4'd3,
    PS_HALT_SNP  = 4'd4,
    PS_DEEP_SNP  = 4'd5,
    PS_SGNT_SNP  = 4'd6,
    PS_DEEP_IN   = 4'd7,
    PS_DEEP_OUT  = 4'd8,
    PS_SGNT_WAIT = 4'd9
  } pstate_t;

  localparam int NUM_LATCHED = 4;

  function automatic logic is_low_power(pstate_t s);
    return (s == PS_HALT) || (s == PS_DEEP) || (s == PS_SGNT) ||
           (s == PS_HALT_SNP) || (s == PS_DEEP_SNP) || (s == PS_SGNT_SNP);
  endfunction

  function automatic logic is_stopped(pstate_t s);
    return (s == PS_SGNT_WAIT) || (s == PS_SGNT) || (s == PS_SGNT_SNP);
  endfunction
endpackage

// File: rtl/lps_all_halted.sv
module lps_all_halted #(
  parameter int NCORES = 4
) (
  input  logic [NCORES-1:0] halted,
  output logic              all_halted
);
  logic [NCORES:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < NCORES; i++) begin : g_and
    assign chain[i+1] = chain[i] & halted[i];
  end
  assign all_halted = chain[NCORES];
endmodule

// File: rtl/lps_sg_timer.sv
module lps_sg_timer #(
  parameter int DELAY = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int W = $clog2(DELAY + 1);
  localparam logic [W-1:0] LOAD_V = W'(DELAY);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= LOAD_V;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == W'(1));

  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lps_evt_latch.sv
module lps_evt_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_en,
  input  logic [N-1:0] evt,
  input  logic         fire,
  output logic         any_pending,
  output logic [N-1:0] replay
);
  logic [N-1:0] pend_q;
  logic [N-1:0] captured;

  for (genvar i = 0; i < N; i++) begin : g_evt
    assign captured[i] = pend_q[i] | (capture_en & evt[i]);
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        replay[i] <= 1'b0;
      end else if (fire) begin
        pend_q[i] <= 1'b0;
        replay[i] <= captured[i];
      end else begin
        pend_q[i] <= captured[i];
        replay[i] <= 1'b0;
      end
    end
  end

  assign any_pending = |captured;

  assert_replay_once_R9: assert property (@(posedge clk) disable iff (rst)
    (|replay) |=> (replay == '0));
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl #(
  parameter int NCORES   = 4,
  parameter int SG_DELAY = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] core_halted,
  input  logic              deep_en,
  input  logic              stpclk_n,
  input  logic              snoop_hit,
  input  logic              snoop_done,
  input  logic              proc_reset,
  input  logic              brk_smi,
  input  logic              brk_init,
  input  logic              brk_nmi,
  input  logic              brk_intr,
  input  logic              brk_bus,
  input  logic              sg_ack_rsp,
  input  logic              oppt_lower_done,
  input  logic              oppt_restore_done,
  output logic [3:0]        state,
  output logic              sg_ack_req,
  output logic              psi_n,
  output logic              oppt_lower_req,
  output logic              oppt_restore_req,
  output logic [3:0]        replay
);
  import lps_pkg::*;

  pstate_t cur, nxt, ret_q;
  logic    all_halted, sg_expire, any_pending, wake, fire;
  logic [NUM_LATCHED-1:0] evt_vec;

  lps_all_halted #(.NCORES(NCORES)) u_halt (
    .halted(core_halted), .all_halted(all_halted));

  lps_sg_timer #(.DELAY(SG_DELAY)) u_timer (
    .clk(clk), .rst(rst),
    .load(sg_ack_rsp && cur == PS_SGNT_WAIT),
    .expire(sg_expire));

  assign evt_vec = {brk_intr, brk_nmi, brk_init, brk_smi};
  assign fire    = (nxt == PS_RUN) && (cur != PS_RUN);

  lps_evt_latch #(.N(NUM_LATCHED)) u_latch (
    .clk(clk), .rst(rst), .capture_en(is_stopped(cur)), .evt(evt_vec),
    .fire(fire), .any_pending(any_pending), .replay(replay));

  assign wake = brk_smi | brk_init | brk_nmi | brk_intr | brk_bus | proc_reset;

  always_comb begin
    nxt = cur;
    unique case (cur)
      PS_RUN: begin
        if (!stpclk_n)       nxt = PS_SGNT_WAIT;
        else if (all_halted) nxt = deep_en ? PS_DEEP_IN : PS_HALT;
      end
      PS_HALT: begin
        if (wake)            nxt = PS_RUN;
        else if (!stpclk_n)  nxt = PS_SGNT_WAIT;
        else if (snoop_hit)  nxt = PS_HALT_SNP;
      end
      PS_DEEP: begin
        if (wake)            nxt = PS_DEEP_OUT;
        else if (!stpclk_n)  nxt = PS_SGNT_WAIT;
        else if (snoop_hit)  nxt = PS_DEEP_SNP;
      end
      PS_DEEP_IN:   if (oppt_lower_done)   nxt = PS_DEEP;
      PS_DEEP_OUT:  if (oppt_restore_done) nxt = PS_RUN;
      PS_SGNT_WAIT: if (sg_expire)         nxt = PS_SGNT;
      PS_SGNT: begin
        if (stpclk_n) begin
          case (ret_q)
            PS_HALT: nxt = any_pending ? PS_RUN : PS_HALT;
            PS_DEEP: nxt = any_pending ? PS_DEEP_OUT : PS_DEEP;
            default: nxt = PS_RUN;
          endcase
        end else if (snoop_hit) begin
          nxt = PS_SGNT_SNP;
        end
      end
      PS_HALT_SNP:  if (snoop_done) nxt = PS_HALT;
      PS_DEEP_SNP:  if (snoop_done) nxt = PS_DEEP;
      PS_SGNT_SNP:  if (snoop_done) nxt = PS_SGNT;
      default:      nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur              <= PS_RUN;
      ret_q            <= PS_RUN;
      sg_ack_req       <= 1'b0;
      psi_n            <= 1'b1;
      oppt_lower_req   <= 1'b0;
      oppt_restore_req <= 1'b0;
    end else begin
      cur              <= nxt;
      if (nxt == PS_SGNT_WAIT && cur != PS_SGNT_WAIT) ret_q <= cur;
      sg_ack_req       <= (nxt == PS_SGNT_WAIT) && (cur != PS_SGNT_WAIT);
      psi_n            <= !is_low_power(nxt);
      oppt_lower_req   <= (nxt == PS_DEEP_IN);
      oppt_restore_req <= (nxt == PS_DEEP_OUT);
    end
  end

  assign state = cur;

  assert_partial_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_RUN && stpclk_n && !(&core_halted)) |=> (state == 4'd0));
  assert_deep_entry_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_DEEP_IN && !oppt_lower_done) |=> (state == 4'd7 && oppt_lower_req));
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    sg_ack_req |=> !sg_ack_req);
  assert_reset_in_sgnt_R8: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_SGNT && !stpclk_n && !snoop_hit) |=> (state == 4'd3));
  assert_snoop_return_R11: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_HALT_SNP && snoop_done) |=> (state == 4'd1));
  assert_deep_snoop_low_R13: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd5) |-> (!psi_n && !oppt_restore_req));
endmodule

// File: tb/lps_ctrl_test.sv
module lps_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, deep_en, stpclk_n, snoop_hit, snoop_done, proc_reset;
  logic brk_smi, brk_init, brk_nmi, brk_intr, brk_bus;
  logic sg_ack_rsp, oppt_lower_done, oppt_restore_done;
  logic [NC-1:0] core_halted;
  logic [3:0] state, replay;
  logic sg_ack_req, psi_n, oppt_lower_req, oppt_restore_req;

  lps_ctrl #(.NCORES(NC), .SG_DELAY(20)) uut (
    .clk(clk), .rst(rst), .core_halted(core_halted), .deep_en(deep_en),
    .stpclk_n(stpclk_n), .snoop_hit(snoop_hit), .snoop_done(snoop_done),
    .proc_reset(proc_reset), .brk_smi(brk_smi), .brk_init(brk_init),
    .brk_nmi(brk_nmi), .brk_intr(brk_intr), .brk_bus(brk_bus),
    .sg_ack_rsp(sg_ack_rsp), .oppt_lower_done(oppt_lower_done),
    .oppt_restore_done(oppt_restore_done), .state(state),
    .sg_ack_req(sg_ack_req), .psi_n(psi_n), .oppt_lower_req(oppt_lower_req),
    .oppt_restore_req(oppt_restore_req), .replay(replay));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_evts(int s);
    brk_smi = s[0]; brk_init = s[1]; brk_nmi = s[2]; brk_intr = s[3];
  endtask

  task automatic clear_in();
    core_halted = '0; deep_en = 0; stpclk_n = 1; snoop_hit = 0; snoop_done = 0;
    proc_reset = 0; set_evts(0); brk_bus = 0; sg_ack_rsp = 0;
    oppt_lower_done = 0; oppt_restore_done = 0;
  endtask

  task automatic do_reset();
    clear_in(); rst = 1; step(); step(); rst = 0;
  endtask

  task automatic go_idle(bit d);
    deep_en = d; core_halted = '1; step();
    if (d) begin oppt_lower_done = 1; step(); oppt_lower_done = 0; end
    check(d ? "R3 deep reached" : "R3 halt reached", state, d ? 2 : 1);
  endtask

  task automatic to_sgnt();
    stpclk_n = 0; step();
    check("R5 wait state", state, 9);
    check("R5 ack pulse", sg_ack_req, 1);
    step();
    check("R5 ack single", sg_ack_req, 0);
    sg_ack_rsp = 1; step(); sg_ack_rsp = 0;
    for (int k = 1; k < 20; k++) step();
    check("R6 not early", state, 9);
    step();
    check("R6 stop-grant at delay", state, 3);
    check("R12 psi in stop-grant", psi_n, 0);
  endtask

  task automatic set_wake(int w, bit v);
    case (w)
      0: brk_smi = v; 1: brk_init = v; 2: brk_nmi = v;
      3: brk_intr = v; 4: brk_bus = v; default: proc_reset = v;
    endcase
  endtask

  initial begin
    clear_in(); rst = 1;
    step(); step();
    check("R1 reset state", state, 0);
    check("R1 reset psi_n", psi_n, 1);
    check("R1 reset ack", sg_ack_req, 0);
    check("R1 reset lower", oppt_lower_req, 0);
    check("R1 reset restore", oppt_restore_req, 0);
    check("R1 reset replay", replay, 0);
    rst = 0;

    // R2 / R3: all halt patterns against the deep strap
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < (1 << NC); p++) begin
        do_reset(); deep_en = d[0]; core_halted = p[NC-1:0]; step();
        check("R2 idle only when all halted", state,
              (p == (1 << NC) - 1) ? (d ? 7 : 1) : 0);
        if (p == (1 << NC) - 1) begin
          check("R12 psi_n on entry", psi_n, d ? 1 : 0);
          check("R3 lower request", oppt_lower_req, d);
        end
      end
    end

    // R3: deep entry waits for the sequencer
    do_reset(); deep_en = 1; core_halted = '1; step(); step(); step();
    check("R3 deep entry held", state, 7);
    oppt_lower_done = 1; step(); oppt_lower_done = 0;
    check("R3 deep reached", state, 2);
    check("R3 lower dropped", oppt_lower_req, 0);

    // R4: every wake cause out of both idle states
    for (int d = 0; d < 2; d++) begin
      for (int w = 0; w < 6; w++) begin
        do_reset(); go_idle(d[0]);
        core_halted = '0; set_wake(w, 1); step(); set_wake(w, 0);
        if (d == 0) begin
          check("R4 halt wake", state, 0);
        end else begin
          check("R4 deep exit", state, 8);
          check("R4 restore request", oppt_restore_req, 1);
          check("R12 psi_n in exit", psi_n, 1);
          step();
          check("R4 exit held", state, 8);
          oppt_restore_done = 1; step(); oppt_restore_done = 0;
          check("R4 run after restore", state, 0);
          check("R4 restore dropped", oppt_restore_req, 0);
        end
      end
    end

    // R7: return target from run, halt and deep
    do_reset(); to_sgnt(); stpclk_n = 1; step();
    check("R7 back to run", state, 0);
    for (int d = 0; d < 2; d++) begin
      do_reset(); go_idle(d[0]); to_sgnt(); stpclk_n = 1; step();
      check("R7 back to idle", state, d ? 2 : 1);
      check("R13 no restore on return", oppt_restore_req, 0);
    end

    // R8: processor reset inside stop-grant
    do_reset(); to_sgnt(); proc_reset = 1; step(); proc_reset = 0;
    check("R8 reset keeps stop-grant", state, 3);
    step();
    check("R8 still stop-grant", state, 3);

    // R11 / R13: snoops from each idle state
    do_reset(); to_sgnt();
    snoop_hit = 1; step(); snoop_hit = 0;
    check("R11 stop-grant snoop", state, 6);
    step(); check("R11 snoop held", state, 6);
    snoop_done = 1; step(); snoop_done = 0;
    check("R11 back to stop-grant", state, 3);
    for (int d = 0; d < 2; d++) begin
      do_reset(); go_idle(d[0]);
      snoop_hit = 1; step(); snoop_hit = 0;
      check("R11 idle snoop", state, d ? 5 : 4);
      check("R12 psi_n in snoop", psi_n, 0);
      check("R13 no restore in snoop", oppt_restore_req, 0);
      step(); check("R11 snoop held", state, d ? 5 : 4);
      snoop_done = 1; step(); snoop_done = 0;
      check("R11 snoop return", state, d ? 2 : 1);
    end

    // R9: every subset of latched events, each raised twice, bus interrupt too
    for (int s = 0; s < 16; s++) begin
      do_reset(); to_sgnt();
      set_evts(s); brk_bus = 1; step(); step();
      set_evts(0); brk_bus = 0;
      check("R9 stays stopped", state, 3);
      check("R9 no early replay", replay, 0);
      stpclk_n = 1; step();
      check("R9 return to run", state, 0);
      check("R9 replay word", replay, s);
      step();
      check("R9 replay single", replay, 0);
    end

    // R10: pending event while returning to an idle state
    do_reset(); go_idle(0); to_sgnt();
    set_evts(1); step(); set_evts(0);
    stpclk_n = 1; step();
    check("R10 halt target wakes", state, 0);
    check("R10 halt replay", replay, 1);
    do_reset(); go_idle(1); to_sgnt();
    set_evts(8); step(); set_evts(0);
    stpclk_n = 1; step();
    check("R10 deep target exits", state, 8);
    check("R10 no replay yet", replay, 0);
    oppt_restore_done = 1; step(); oppt_restore_done = 0;
    check("R10 run after restore", state, 0);
    check("R10 deep replay", replay, 8);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule